// File: doc/BRIEF.md
# Single-Frame Transmit Buffer

This block holds one outgoing frame that a host loads word by word through a small register interface and then hands to a byte-wide MAC-side stream. The host writes 32-bit data words into a data register, then writes a control register carrying the frame's byte length together with a go bit. From that write on, the block streams exactly that many bytes toward the MAC. Within each word the most significant byte goes first. The block then waits for the MAC side to report the end of transmission. On that report it clears the go bit, latches the reported failure as an error flag, resets its word pointer and raises a transmit-done interrupt cause.

Only one frame is in flight at a time. The go bit therefore also acts as the busy flag. Data and control writes made while it is set are refused. A refused data write, or one that would overrun the word store, sets a sticky overflow flag. The length that is streamed comes only from the control write, never from the number of words loaded.

Top module: `tx_frame_buffer`

## Requirements
- R1: After reset the control register, the interrupt enable and cause registers, `irq` and `tx_valid` all read 0.
- R2: After a start, the block sends exactly the programmed number of bytes in load order, most significant byte of each word first, and asserts `tx_last` only on the final byte.
- R3: A data-register write (byte address 0x808) made while go is set, or when all word slots are full, is discarded and sets the overflow flag at control bit 18.
- R4: The go bit (control bit 16, byte address 0x800) reads 1 from the accepted start until completion, and `tx_valid` is never high while go reads 0.
- R5: The error flag (control bit 17) takes the value of `mac_err` sampled with `mac_cmpl`, and it is cleared by the next start.
- R6: The length field, control bits 31:21, reads back the value last accepted.
- R7: Completion sets transmit-done at bit 1 of the cause register (byte address 0x8C4). Writing 1 to that bit clears it, and bit 0 always reads 0.
- R8: `irq` is high exactly when a cause bit and the matching bit of the enable register (byte address 0x8C0) are both 1, so writing 0 to the enable register masks every cause.
- R9: A control write made while go is set changes neither the length nor the frame in flight.
- R10: The word pointer returns to slot 0 at completion, so the next frame's first word is sent from the start.
- R11: A start with length 0 sends no byte, completes without any MAC report, and leaves the error flag at 0.
- R12: A control write that is accepted and has bit 18 set clears the overflow flag.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 13 | Register byte address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| tx_valid | output | 1 | A frame byte is offered to the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | The offered byte is the final one |
| tx_ready | input | 1 | MAC accepts the offered byte |
| mac_cmpl | input | 1 | MAC reports the end of transmission (one-cycle pulse) |
| mac_err | input | 1 | Failure flag, qualified by mac_cmpl |
| irq | output | 1 | Interrupt request |

## Verification
The case hardest to reach from the ports is a host write arriving while a frame is still in flight. Normally the MAC drains the frame before the host can react. The bench reaches this case by holding `tx_ready` low right after a start, which freezes the frame. While it is frozen, the bench issues a stray data write and a conflicting control write, reads back the overflow flag, the length and the go bit, and then releases the MAC side. The scoreboard then confirms that the original bytes still leave unchanged. The full-store overrun is reached by loading one word more than the store holds. The bench then issues a zero-length start, which is the only way to recover the pointer without sending the whole store.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    localparam int ADDR_W = 13;
    localparam int LEN_W  = 11;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 13'h800;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 13'h808;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 13'h8C0;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 13'h8C4;

    // control word seen by the host; the layout is decoded by software
    typedef struct packed {
        logic [LEN_W-1:0] len;   // 31:21
        logic [1:0]       rsvd;  // 20:19
        logic             ovf;   // 18
        logic             err;   // 17
        logic             go;    // 16
        logic [15:0]      low;   // 15:0
    } ctl_word_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_SEND = 2'd1,
        SER_WAIT = 2'd2
    } ser_state_e;

    // byte lane 0 is the most significant byte of a word
    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        logic [7:0] b;
        case (lane)
            2'd0:    b = w[31:24];
            2'd1:    b = w[23:16];
            2'd2:    b = w[15:8];
            default: b = w[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txbuf_word_store.sv
module txbuf_word_store #(
    parameter  int LEN_W = 11,
    localparam int IDX_W = LEN_W - 2,
    localparam int PTR_W = LEN_W - 1,
    localparam int DEPTH = 2 ** IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [31:0]      wdata_i,
    input  logic             clr_ptr_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [31:0]      rd_word_o,
    output logic             full_o
);
    logic [31:0]      mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem[ptr_q[IDX_W-1:0]] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (clr_ptr_i) begin
            ptr_q <= '0;
        end else if (wr_i) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    assign full_o    = (ptr_q == PTR_W'(DEPTH));
    assign rd_word_o = mem[rd_idx_i];

endmodule

// File: rtl/txbuf_serializer.sv
module txbuf_serializer
    import txbuf_pkg::*;
#(
    parameter  int LEN_W = 11,
    localparam int IDX_W = LEN_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [IDX_W-1:0] word_idx_o,
    input  logic [31:0]      word_i,
    output logic             tx_valid_o,
    output logic [7:0]       tx_data_o,
    output logic             tx_last_o,
    input  logic             tx_ready_i,
    input  logic             mac_cmpl_i,
    input  logic             mac_err_i,
    output logic             done_o,
    output logic             done_err_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    ser_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;
    logic             derr_q;
    logic             at_last;

    assign at_last = (cnt_q == len_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
            derr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SER_IDLE: begin
                    if (start_i) begin
                        if (len_i == '0) begin
                            done_q <= 1'b1;
                            derr_q <= 1'b0;
                        end else begin
                            state_q <= SER_SEND;
                            cnt_q   <= '0;
                            len_q   <= len_i;
                        end
                    end
                end
                SER_SEND: begin
                    if (tx_ready_i) begin
                        if (at_last) begin
                            state_q <= SER_WAIT;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                end
                SER_WAIT: begin
                    if (mac_cmpl_i) begin
                        done_q  <= 1'b1;
                        derr_q  <= mac_err_i;
                        state_q <= SER_IDLE;
                    end
                end
                default: state_q <= SER_IDLE;
            endcase
        end
    end

    assign tx_valid_o = (state_q == SER_SEND);
    assign tx_last_o  = tx_valid_o && at_last;
    assign word_idx_o = cnt_q[LEN_W-1:2];
    assign tx_data_o  = pick_byte(word_i, cnt_q[1:0]);
    assign done_o     = done_q;
    assign done_err_o = derr_q;

endmodule

// File: rtl/txbuf_irq_regs.sv
module txbuf_irq_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr_i,
    input  logic       cause_wr_i,
    input  logic [1:0] wdata_i,
    input  logic       set_tx_done_i,
    output logic [1:0] en_o,
    output logic [1:0] cause_o,
    output logic       irq_o
);
    logic [1:0] en_q;
    logic       txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            txd_q <= 1'b0;
        end else begin
            if (en_wr_i) begin
                en_q <= wdata_i;
            end
            if (set_tx_done_i) begin
                txd_q <= 1'b1;
            end else if (cause_wr_i && wdata_i[1]) begin
                txd_q <= 1'b0;
            end
        end
    end

    // bit 0 belongs to a receive source that lives elsewhere
    assign cause_o = {txd_q, 1'b0};
    assign en_o    = en_q;
    assign irq_o   = |(cause_o & en_q);

endmodule

// File: rtl/tx_frame_buffer.sv
module tx_frame_buffer
    import txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              mac_cmpl,
    input  logic              mac_err,
    output logic              irq
);
    localparam int IDX_W = LEN_W - 2;

    ctl_word_t        wr_ctl;
    logic             data_hit, ctrl_hit, data_take, ctrl_take, start;
    logic             go_q, err_q, ovf_q;
    logic [LEN_W-1:0] len_q;
    logic             full, done, done_err;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      rd_word;
    logic [1:0]       en_v, cause_v;

    assign wr_ctl    = ctl_word_t'(host_wdata);
    assign data_hit  = host_wr && (host_addr == OFS_DATA);
    assign ctrl_hit  = host_wr && (host_addr == OFS_CTRL);
    assign data_take = data_hit && !go_q && !full;
    assign ctrl_take = ctrl_hit && !go_q;
    assign start     = ctrl_take && wr_ctl.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q  <= 1'b0;
            err_q <= 1'b0;
            ovf_q <= 1'b0;
            len_q <= '0;
        end else begin
            if (ctrl_take) begin
                len_q <= wr_ctl.len;
            end
            if (start) begin
                go_q  <= 1'b1;
                err_q <= 1'b0;
            end else if (done) begin
                go_q  <= 1'b0;
                err_q <= done_err;
            end
            if (data_hit && (go_q || full)) begin
                ovf_q <= 1'b1;
            end else if (ctrl_take && wr_ctl.ovf) begin
                ovf_q <= 1'b0;
            end
        end
    end

    txbuf_word_store #(.LEN_W(LEN_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (data_take),
        .wdata_i  (host_wdata),
        .clr_ptr_i(done),
        .rd_idx_i (rd_idx),
        .rd_word_o(rd_word),
        .full_o   (full)
    );

    txbuf_serializer #(.LEN_W(LEN_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .len_i     (wr_ctl.len),
        .word_idx_o(rd_idx),
        .word_i    (rd_word),
        .tx_valid_o(tx_valid),
        .tx_data_o (tx_data),
        .tx_last_o (tx_last),
        .tx_ready_i(tx_ready),
        .mac_cmpl_i(mac_cmpl),
        .mac_err_i (mac_err),
        .done_o    (done),
        .done_err_o(done_err)
    );

    txbuf_irq_regs u_irq (
        .clk          (clk),
        .rst          (rst),
        .en_wr_i      (host_wr && (host_addr == OFS_IEN)),
        .cause_wr_i   (host_wr && (host_addr == OFS_CAUSE)),
        .wdata_i      (host_wdata[1:0]),
        .set_tx_done_i(done),
        .en_o         (en_v),
        .cause_o      (cause_v),
        .irq_o        (irq)
    );

    always_comb begin
        ctl_word_t rd_ctl;
        rd_ctl      = '0;
        rd_ctl.len  = len_q;
        rd_ctl.ovf  = ovf_q;
        rd_ctl.err  = err_q;
        rd_ctl.go   = go_q;
        case (host_addr)
            OFS_CTRL:  host_rdata = rd_ctl;
            OFS_IEN:   host_rdata = {30'd0, en_v};
            OFS_CAUSE: host_rdata = {30'd0, cause_v};
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tx_frame_buffer_checker.sv
module tx_frame_buffer_checker
    import txbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [31:0]       host_wdata,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready,
    input logic              go_q,
    input logic              ovf_q,
    input logic [LEN_W-1:0]  len_q,
    input logic [1:0]        cause_v,
    input logic              irq
);
    p_valid_needs_go_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> go_q);

    p_last_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    p_hold_on_stall_r13: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_DATA && go_q) |=> ovf_q);

    p_busy_ctrl_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_CTRL && go_q) |=> $stable(len_q));

    p_done_sets_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(go_q) |-> cause_v[1]);

    p_mask_all_r8: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_IEN && host_wdata[1:0] == 2'b00) |=> !irq);

endmodule

bind tx_frame_buffer tx_frame_buffer_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .go_q      (go_q),
    .ovf_q     (ovf_q),
    .len_q     (len_q),
    .cause_v   (cause_v),
    .irq       (irq)
);

// File: tb/sim_tx_frame_buffer.sv
module sim_tx_frame_buffer;
    import txbuf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              tx_valid, tx_last, irq;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b0;
    logic              mac_cmpl = 1'b0;
    logic              mac_err = 1'b0;

    always #2.5 clk = ~clk;

    tx_frame_buffer u0 (.*);

    logic [7:0] exp_q [$];
    int host_checks = 0, host_errs = 0;
    int mon_checks = 0, mon_errs = 0;
    int last_seen = 0, served = 0;
    int ready_mode = 1;      // 0 hold low, 1 always high, 2 pattern
    logic err_sel = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic prev_last = 1'b0;
    bit finished = 0;

    // MAC-side model
    always @(posedge clk) begin
        #1;
        mac_cmpl = 1'b0;
        if (last_seen != served) begin
            mac_cmpl = 1'b1;
            mac_err  = err_sel;
            served   = served + 1;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ready_mode)
            0:       tx_ready = 1'b0;
            1:       tx_ready = 1'b1;
            default: tx_ready = lfsr[0];
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                mon_checks++;
                if (!tx_valid || tx_data != prev_data || tx_last != prev_last) begin
                    mon_errs++;
                    $display("FAIL R13 stall hold: valid=%0b data=%h last=%0b expected 1/%h/%0b",
                             tx_valid, tx_data, tx_last, prev_data, prev_last);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
            if (tx_valid && tx_ready) begin
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_errs++;
                    $display("FAIL R2 unexpected byte: actual=%h expected none", tx_data);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (tx_data != e || tx_last != (exp_q.size() == 0)) begin
                        mon_errs++;
                        $display("FAIL R2 byte: actual=%h last=%0b expected=%h last=%0b",
                                 tx_data, tx_last, e, exp_q.size() == 0);
                    end
                end
                if (tx_last) last_seen = last_seen + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        host_checks++;
        if (act !== exp) begin
            host_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'((seed * 7 + i * 13 + (i >> 3)) & 255);
    endfunction

    function automatic logic [31:0] ctl(input int len, input bit go, input bit ovfclr);
        return (32'(len) << 21) | (32'(go) << 16) | (32'(ovfclr) << 18);
    endfunction

    // load words, push expected bytes, start
    task automatic load_frame(input int len, input int seed);
        for (int j = 0; j < (len + 3) / 4; j++) begin
            logic [31:0] w;
            w = '0;
            for (int k = 0; k < 4; k++) begin
                if (4 * j + k < len) w[31 - 8*k -: 8] = fbyte(seed, 4 * j + k);
            end
            wr(OFS_DATA, w);
        end
        for (int i = 0; i < len; i++) exp_q.push_back(fbyte(seed, i));
        wr(OFS_CTRL, ctl(len, 1'b1, 1'b0));
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n;
        n = 0;
        rd(OFS_CTRL, v);
        while (v[16] && n < 20000) begin
            rd(OFS_CTRL, v);
            n++;
        end
        if (v[16]) check("R4 completion timeout", 32'(v[16]), 32'd0);
    endtask

    task automatic after_frame(input string tag, input int len, input bit exp_err);
        logic [31:0] v;
        check({tag, " R2 all bytes sent"}, 32'(exp_q.size()), 32'd0);
        rd(OFS_CTRL, v);
        check({tag, " R5 error flag"}, 32'(v[17]), 32'(exp_err));
        check({tag, " R6 length"}, 32'(v[31:21]), 32'(len));
        rd(OFS_CAUSE, v);
        check({tag, " R7 tx done cause"}, v, 32'h2);
        check({tag, " R8 irq enabled"}, 32'(irq), 32'd1);
        wr(OFS_CAUSE, 32'h2);
        rd(OFS_CAUSE, v);
        check({tag, " R7 cause cleared"}, v, 32'h0);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", host_errs + mon_errs, host_checks + mon_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            host_errs++;
            host_checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(OFS_CTRL, v);  check("R1 control", v, 32'h0);
        rd(OFS_IEN, v);   check("R1 enable", v, 32'h0);
        rd(OFS_CAUSE, v); check("R1 cause", v, 32'h0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 tx_valid", 32'(tx_valid), 32'd0);

        wr(OFS_IEN, 32'h2);

        // R2 plain frame
        ready_mode = 1; err_sel = 1'b0;
        load_frame(13, 1); wait_done(); after_frame("A", 13, 1'b0);

        // R5 error report, R13 stalls
        ready_mode = 2; err_sel = 1'b1;
        load_frame(8, 2); wait_done(); after_frame("B", 8, 1'b1);

        // R5 error cleared by next start, single byte
        err_sel = 1'b0;
        load_frame(1, 3); wait_done(); after_frame("C", 1, 1'b0);

        // R3 R9 R4 writes while busy
        ready_mode = 0;
        load_frame(6, 4);
        wr(OFS_DATA, 32'hDEADBEEF);
        rd(OFS_CTRL, v);
        check("R3 overflow on busy write", 32'(v[18]), 32'd1);
        check("R4 go while busy", 32'(v[16]), 32'd1);
        wr(OFS_CTRL, ctl(3, 1'b1, 1'b1));
        rd(OFS_CTRL, v);
        check("R9 length kept", 32'(v[31:21]), 32'd6);
        check("R9 overflow not cleared while busy", 32'(v[18]), 32'd1);
        ready_mode = 2;
        wait_done(); after_frame("D", 6, 1'b0);

        // R12 overflow clear
        wr(OFS_CTRL, ctl(0, 1'b0, 1'b1));
        rd(OFS_CTRL, v);
        check("R12 overflow cleared", 32'(v[18]), 32'd0);

        // R8 mask all
        ready_mode = 1;
        load_frame(4, 5); wait_done();
        wr(OFS_IEN, 32'h0);
        check("R8 masked irq", 32'(irq), 32'd0);
        rd(OFS_CAUSE, v);
        check("R8 cause still set", v, 32'h2);
        wr(OFS_IEN, 32'h2);
        check("R8 unmasked irq", 32'(irq), 32'd1);
        wr(OFS_CAUSE, 32'h2);

        // R3 full store, R11 zero length resets pointer
        for (int j = 0; j < 513; j++) wr(OFS_DATA, 32'(j));
        rd(OFS_CTRL, v);
        check("R3 overflow on full store", 32'(v[18]), 32'd1);
        wr(OFS_CTRL, ctl(0, 1'b1, 1'b1));
        wait_done();
        after_frame("Z R11", 0, 1'b0);
        rd(OFS_CTRL, v);
        check("R12 overflow cleared by start", 32'(v[18]), 32'd0);

        // R10 pointer back at slot 0
        ready_mode = 2;
        load_frame(9, 6); wait_done(); after_frame("E R10", 9, 1'b0);

        // R2 longest frame fills the store exactly
        ready_mode = 1;
        load_frame(2047, 7); wait_done(); after_frame("F", 2047, 1'b0);

        repeat (4) @(posedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule